// File: doc/BRIEF.md
# Priority-Grouped Vectored Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. Each line has its own programmable urgency value, enable bit and handler address. The controller picks the most urgent enabled pending line, asks the core to save its context, and then hands the core the handler address from its table. Whether a new request may interrupt a running handler depends only on the upper "group" bits of the urgency value. The number of those bits is set by a split-point register. The lower bits only order requests that wait within the same group.

The controller keeps a stack of the handlers that are currently active, so that nested handlers return in order. When a handler finishes while another request is waiting that may run, the controller moves straight to the next handler without a restore and re-save of the context (tail-chaining). While the core is still saving context, a more urgent request that arrives in the meantime takes the place of the original target (late arrival).

The sequencer has three states. IDLE means no entry is in progress: a thread or a handler is running. STACK means the core is saving context. VECTOR is a single cycle in which the handler address is delivered. The transitions are:

- IDLE to STACK on a preempting request.
- IDLE to VECTOR on a return that tail-chains.
- IDLE to IDLE on a plain return.
- STACK to STACK while the save is still in progress, retargeting on a late arrival.
- STACK to VECTOR on save completion.
- VECTOR to IDLE always.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset nothing is pending or active: `take_o`, `vec_valid` and `act_vld` are 0, and the split point equals PRIO_W.
- R2: An entry produces a one-cycle `vec_valid` pulse. In that cycle `vec_addr` is the address programmed for the chosen line and `vec_id` is that line's number. The line becomes the top of the active stack.
- R3: Among enabled pending lines, the lowest urgency value wins. Equal values are decided in favour of the lower line number.
- R4: The group of an urgency value is its upper `split` bits. A pending line preempts the running handler (or idle thread) only if its group value is numerically lower than the running handler's group value.
- R5: A pending line whose group equals that of the running handler never preempts it, even when its full urgency value is lower.
- R6: `take_o` rises two clock edges after a request edge that is allowed to preempt. It stays high until `save_done` is seen at an edge. `vec_valid` follows in the next cycle.
- R7: If, while `take_o` is high, a line with a strictly lower urgency value than the current target becomes pending, the delivered vector is that newer line's.
- R8: On `exc_return`, if a pending line would preempt the context being returned to, the controller enters VECTOR in the next cycle with `vec_chain`=1 and no `take_o`.
- R9: A plain `exc_return` pops the active stack, so that `act_id` again shows the interrupted handler, or `act_vld` drops to 0.
- R10: A disabled line still becomes pending on a request edge but is never selected. Once it is enabled, it is taken.
- R11: A line becomes pending on a 0-to-1 edge of its request and is cleared in its VECTOR cycle. A request held high does not become pending again.
- R12: Configuration writes with `cfg_we`=1 use `cfg_kind` as follows: 0 sets the urgency of line `cfg_idx` from `cfg_wdata[PRIO_W-1:0]`, 1 sets its enable from `cfg_wdata[0]`, 2 sets its handler address, and 3 sets the split point, saturated at PRIO_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 0 urgency, 1 enable, 2 address, 3 split |
| cfg_idx | input | IDX_W | Line addressed by the write |
| cfg_wdata | input | VEC_W | Write data |
| irq_req | input | N_IRQ | Request lines, edge sensitive |
| save_done | input | 1 | Core has finished saving context |
| exc_return | input | 1 | Running handler has finished |
| take_o | output | 1 | Core must save context now |
| vec_valid | output | 1 | Handler address valid, one cycle |
| vec_addr | output | VEC_W | Handler address |
| vec_id | output | IDX_W | Line number of the handler |
| vec_chain | output | 1 | Entry was tail-chained, no save took place |
| act_vld | output | 1 | At least one handler is active |
| act_id | output | IDX_W | Line number of the innermost active handler |

## Verification
All bench stimulus changes just after a falling edge. A request is registered as pending at the first rising edge, and `take_o` is therefore sampled at the second falling edge after the request. The vector pulse is due at the falling edge after the edge that sees `save_done` or `exc_return`, and the scoreboard monitor pops its expected entry exactly there. Active-stack state is checked one falling edge after that pulse, and absence of preemption is checked over several cycles after each non-preempting request.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STACK  = 2'd1,
        ST_VECTOR = 2'd2
    } pic_state_e;

    localparam logic [1:0] CFG_PRIO   = 2'd0;
    localparam logic [1:0] CFG_ENABLE = 2'd1;
    localparam logic [1:0] CFG_VECTOR = 2'd2;
    localparam logic [1:0] CFG_SPLIT  = 2'd3;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 32,
    parameter int IDX_W   = 3,
    parameter int SPLIT_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [1:0]                        cfg_kind,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic [VEC_W-1:0]                  cfg_wdata,
    output logic [N_IRQ-1:0][PRIO_W-1:0]      prio_r,
    output logic [N_IRQ-1:0]                  en_r,
    output logic [N_IRQ-1:0][VEC_W-1:0]       vec_r,
    output logic [SPLIT_W-1:0]                split_r
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic hit;
        assign hit = cfg_we && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_r[i] <= '0;
                en_r[i]   <= 1'b0;
                vec_r[i]  <= '0;
            end else if (hit) begin
                if (cfg_kind == CFG_PRIO)   prio_r[i] <= cfg_wdata[PRIO_W-1:0];
                if (cfg_kind == CFG_ENABLE) en_r[i]   <= cfg_wdata[0];
                if (cfg_kind == CFG_VECTOR) vec_r[i]  <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_r <= SPLIT_W'(PRIO_W);
        end else if (cfg_we && cfg_kind == CFG_SPLIT) begin
            split_r <= (cfg_wdata > VEC_W'(PRIO_W)) ? SPLIT_W'(PRIO_W)
                                                    : cfg_wdata[SPLIT_W-1:0];
        end
    end
endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] clr,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] req_q;
    logic [N_IRQ-1:0] rise;

    assign rise = req & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr) | rise;
        end
    end
endmodule

// File: rtl/pic_select.sv
module pic_select #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic [N_IRQ-1:0]             pend,
    input  logic [N_IRQ-1:0]             en,
    input  logic [N_IRQ-1:0][PRIO_W-1:0] prio,
    output logic                         sel_vld,
    output logic [IDX_W-1:0]             sel_id,
    output logic [PRIO_W-1:0]            sel_prio
);
    always_comb begin
        sel_vld  = 1'b0;
        sel_id   = '0;
        sel_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (pend[i] && en[i] && (!sel_vld || prio[i] < sel_prio)) begin
                sel_vld  = 1'b1;
                sel_id   = IDX_W'(i);
                sel_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int SPLIT_W = $clog2(PRIO_W + 1),
    localparam int SP_W    = $clog2(DEPTH + 1),
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VEC_W-1:0] cfg_wdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             save_done,
    input  logic             exc_return,
    output logic             take_o,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr,
    output logic [IDX_W-1:0] vec_id,
    output logic             vec_chain,
    output logic             act_vld,
    output logic [IDX_W-1:0] act_id
);
    logic [N_IRQ-1:0][PRIO_W-1:0] prio_r;
    logic [N_IRQ-1:0]             en_r;
    logic [N_IRQ-1:0][VEC_W-1:0]  vec_r;
    logic [SPLIT_W-1:0]           split_r;
    logic [N_IRQ-1:0]             pend;
    logic [N_IRQ-1:0]             clr;
    logic                         sel_vld;
    logic [IDX_W-1:0]             sel_id;
    logic [PRIO_W-1:0]            sel_prio;

    pic_state_e               state, nxt;
    logic [IDX_W-1:0]         target;
    logic                     chain_q;
    logic [DEPTH-1:0][IDX_W-1:0] stk;
    logic [SP_W-1:0]          sp;
    logic [PTR_W-1:0]         top_ptr, below_ptr, push_ptr;
    logic [IDX_W-1:0]         top_id, below_id;
    logic                     preempt, ret_ok, chain_ok, late;

    pic_cfg_regs #(
        .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
        .IDX_W(IDX_W), .SPLIT_W(SPLIT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .prio_r(prio_r),
        .en_r(en_r), .vec_r(vec_r), .split_r(split_r)
    );

    pic_pend #(.N_IRQ(N_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr), .pend(pend)
    );

    pic_select #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
        .pend(pend), .en(en_r), .prio(prio_r),
        .sel_vld(sel_vld), .sel_id(sel_id), .sel_prio(sel_prio)
    );

    function automatic logic [PRIO_W-1:0] grp_of(input logic [PRIO_W-1:0] p,
                                                 input logic [SPLIT_W-1:0] s);
        return p >> (PRIO_W - int'(s));
    endfunction

    // Stack pointers: top is the running handler, below is the one it interrupted
    assign top_ptr   = PTR_W'(sp - SP_W'(1));
    assign below_ptr = PTR_W'(sp - SP_W'(2));
    assign push_ptr  = PTR_W'(sp);
    assign top_id    = stk[top_ptr];
    assign below_id  = stk[below_ptr];

    assign preempt  = sel_vld && (sp < SP_W'(DEPTH)) &&
                      ((sp == '0) ||
                       (grp_of(sel_prio, split_r) < grp_of(prio_r[top_id], split_r)));
    assign ret_ok   = exc_return && (sp != '0);
    assign chain_ok = sel_vld &&
                      ((sp == SP_W'(1)) ||
                       (grp_of(sel_prio, split_r) < grp_of(prio_r[below_id], split_r)));
    assign late     = sel_vld && (sel_prio < prio_r[target]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ret_ok)       nxt = chain_ok ? ST_VECTOR : ST_IDLE;
                else if (preempt) nxt = ST_STACK;
            end
            ST_STACK:  if (save_done) nxt = ST_VECTOR;
            ST_VECTOR: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Target, chain flag and active stack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target  <= '0;
            chain_q <= 1'b0;
            stk     <= '0;
            sp      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ret_ok) begin
                        sp <= sp - SP_W'(1);
                        if (chain_ok) begin
                            target  <= sel_id;
                            chain_q <= 1'b1;
                        end
                    end else if (preempt) begin
                        target  <= sel_id;
                        chain_q <= 1'b0;
                    end
                end
                ST_STACK: if (late) target <= sel_id;
                ST_VECTOR: begin
                    stk[push_ptr] <= target;
                    sp            <= sp + SP_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        take_o    = (state == ST_STACK);
        vec_valid = (state == ST_VECTOR);
        vec_addr  = vec_r[target];
        vec_id    = target;
        vec_chain = vec_valid && chain_q;
        clr       = vec_valid ? (N_IRQ'(1) << target) : '0;
        act_vld   = (sp != '0);
        act_id    = top_id;
    end

    AST_TAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !save_done) |=> take_o);                          // R6
    AST_VEC_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_chain) |-> $past(save_done));             // R6
    AST_CHAIN_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_chain) |-> $past(exc_return));             // R8
    AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);                                   // R2
    AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> (en_r[sel_id] && pend[sel_id]));                 // R10
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [N-1:0] irq_req = '0;
    logic        save_done = 1'b0;
    logic        exc_return = 1'b0;
    logic        take_o, vec_valid, vec_chain, act_vld;
    logic [31:0] vec_addr;
    logic [2:0]  vec_id, act_id;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { int id; logic [31:0] addr; logic chain; } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .irq_req(irq_req),
        .save_done(save_done), .exc_return(exc_return), .take_o(take_o),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_id(vec_id),
        .vec_chain(vec_chain), .act_vld(act_vld), .act_id(act_id)
    );

    function automatic logic [31:0] vaddr(input int i);
        return 32'h0000_8000 + 32'((7 - i) * 32);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] k, input int idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(idx); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic expect_vec(input int id, input logic chain);
        exp_t e;
        e.id = id; e.addr = vaddr(id); e.chain = chain;
        expq.push_back(e);
    endtask

    // Full entry: request already raised at this falling edge
    task automatic enter(input int id, input string tag);
        tick(2);
        chk({tag, " R6 take_o after request"}, 32'(take_o), 1);
        expect_vec(id, 1'b0);
        save_done = 1'b1;
        tick(1);
        save_done = 1'b0;
        tick(1);
        chk({tag, " R2 act_id after entry"}, 32'(act_id), 32'(id));
    endtask

    task automatic ret();
        exc_return = 1'b1;
        tick(1);
        exc_return = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (expq.size() == 0) begin
                chk("R2 unexpected vector id", 32'(vec_id), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R2 vector id", 32'(vec_id), 32'(e.id));
                chk("R2 vector addr", vec_addr, e.addr);
                chk("R8 vector chain flag", 32'(vec_chain), 32'(e.chain));
            end
        end
    end

    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 take_o", 32'(take_o), 0);
        chk("R1 vec_valid", 32'(vec_valid), 0);
        chk("R1 act_vld", 32'(act_vld), 0);

        // R12 configuration: urgency, enable, address, split
        for (int i = 0; i < N; i++) cfg_write(2'd2, i, vaddr(i));
        cfg_write(2'd0, 0, 3); cfg_write(2'd0, 1, 2); cfg_write(2'd0, 2, 6);
        cfg_write(2'd0, 3, 6); cfg_write(2'd0, 4, 3); cfg_write(2'd0, 5, 1);
        cfg_write(2'd0, 6, 4); cfg_write(2'd0, 7, 0);
        for (int i = 0; i < 7; i++) cfg_write(2'd1, i, 1);
        cfg_write(2'd3, 0, 1);

        // R10 disabled line pends but is not selected
        irq_req[7] = 1'b1;
        tick(4);
        chk("R10 disabled line not taken", 32'(take_o), 0);
        cfg_write(2'd1, 7, 1);
        tick(1);
        chk("R10 enabled line taken", 32'(take_o), 1);
        expect_vec(7, 1'b0);
        save_done = 1'b1; tick(1); save_done = 1'b0; tick(1);
        chk("R10 act_id", 32'(act_id), 7);
        ret(); tick(3);
        chk("R11 held request not re-pended", 32'(take_o), 0);
        chk("R9 act_vld after return", 32'(act_vld), 0);
        irq_req[7] = 1'b0;

        // R2/R3 single entry, then R4 preemption by a more urgent group
        irq_req[3] = 1'b1;
        enter(3, "line3");
        irq_req[5] = 1'b1;
        enter(5, "R4 line5 preempts");
        ret(); tick(1);
        chk("R9 act_id restored", 32'(act_id), 3);
        chk("R9 act_vld still set", 32'(act_vld), 1);
        irq_req[5] = 1'b0;

        // R5 same group does not preempt; R8 tail-chain on return
        irq_req[6] = 1'b1;
        tick(4);
        chk("R5 same group no preempt", 32'(take_o), 0);
        expect_vec(6, 1'b1);
        ret();
        chk("R8 no take_o on tail chain", 32'(take_o), 0);
        tick(1);
        chk("R8 act_id after chain", 32'(act_id), 6);
        ret(); tick(1);
        chk("R9 stack empty", 32'(act_vld), 0);
        irq_req[3] = 1'b0; irq_req[6] = 1'b0;

        // R7 late arrival during save
        irq_req[2] = 1'b1;
        tick(2);
        chk("R7 take_o for line2", 32'(take_o), 1);
        irq_req[1] = 1'b1;
        tick(2);
        expect_vec(1, 1'b0);
        save_done = 1'b1; tick(1); save_done = 1'b0; tick(1);
        chk("R7 act_id is late line", 32'(act_id), 1);
        tick(2);
        chk("R7 earlier line waits", 32'(take_o), 0);
        expect_vec(2, 1'b1);
        ret(); tick(1);
        chk("R8 chain to waiting line", 32'(act_id), 2);
        ret(); tick(1);
        irq_req[1] = 1'b0; irq_req[2] = 1'b0;

        // R3 tie: equal urgency, lower number first
        irq_req[0] = 1'b1; irq_req[4] = 1'b1;
        enter(0, "R3 tie lower index");
        expect_vec(4, 1'b1);
        ret(); tick(1);
        chk("R3 second of tie", 32'(act_id), 4);
        ret(); tick(1);
        irq_req[0] = 1'b0; irq_req[4] = 1'b0;

        // R4/R12 wider group field turns a sub-priority into a group
        cfg_write(2'd3, 0, 3);
        irq_req[3] = 1'b1;
        enter(3, "split3 line3");
        irq_req[6] = 1'b1;
        enter(6, "R4 split3 line6 preempts");
        ret(); tick(1);
        chk("R9 back to line3", 32'(act_id), 3);
        ret(); tick(1);
        chk("R9 idle at end", 32'(act_vld), 0);
        irq_req = '0;
        tick(2);

        chk("R2 all expected vectors seen", 32'(expq.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule